// File: doc/BRIEF.md
# Dual-Bank Host DMA Buffer Controller

This controller holds two equal buffer banks that work as a ping-pong pair. An external host streams 32-bit words into one bank through a write port with a valid/ready handshake. The local CPU reads the other bank through its own read port at the same time. Each accepted host word goes to the host address counter. In increment mode the counter moves on by one word (four bytes) after each write. A request line tells an external DMA engine when it may stream.

When a host word lands on the last word of its bank, the controller stops taking data and drops the DMA request. It also sets a sticky bank flag, which can drive an interrupt. Software answers by flipping the bank select so that host and CPU trade banks. This move returns the host counter to the start of the new bank. Software then writes the trigger bit, which raises the request again.

A typical setup loads the counter two words short of the bank end and primes the path with one dummy word. It then triggers the engine.

Top module: `dual_bank_dma_buf`

## Requirements
- R1: After reset, host_dreq and bank_irq are 0 and host_wr_ready is 1. The control, address and status registers all read 0, and cpu_rd_data is 0.
- R2: A host word accepted while the host owns bank b is stored at word haddr[7:2] of bank b. After a swap, a CPU read of address {b, word} returns that word one cycle after cpu_rd_en.
- R3: With the increment bit set (control register, select 0, bit 0), each accepted host write advances the byte address by 4. With it clear, the address holds, so the next write overwrites the same word.
- R4: An accepted write at byte address 252, the last word of a bank, halts the stream. From the next cycle host_wr_ready and host_dreq are 0, and the status register (select 2) reads flag bit 0 = 1 and halted bit 2 = 1.
- R5: A host write presented while halted is ignored: no RAM word and no address change. It sets the sticky overrun status bit 1, which is cleared by writing 1 to it.
- R6: The bank flag stays set until a 1 is written to status bit 0. bank_irq equals the flag gated by the enable bit (control bit 1).
- R7: Writing 1 to bit 0 of the trigger register (select 3) sets host_dreq to 1 and clears the halt from the next cycle. The trigger register always reads 0.
- R8: Writing the control register with a bank bit (bit 2, the host-owned bank) different from the current one swaps ownership, and the host address reads 0 from the next cycle.
- R9: A CPU read of the host-owned bank returns 0.
- R10: The host address register (select 1) is loaded by software with its two low bits forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_valid | input | 1 | Host presents a data word |
| host_wr_data | input | 32 | Host data word |
| host_wr_ready | output | 1 | Port accepts data (not halted) |
| host_dreq | output | 1 | Request toward the external DMA engine |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 address, 2 status, 3 trigger |
| cfg_wdata | input | 32 | CPU register write data |
| cfg_rdata | output | 32 | Selected register value (combinational) |
| cpu_rd_en | input | 1 | CPU buffer read strobe |
| cpu_rd_addr | input | 7 | Bank bit (MSB) and word index |
| cpu_rd_data | output | 32 | Read data, one cycle after the strobe |
| bank_irq | output | 1 | Bank interrupt |

## Verification
Register writes, host words and the halt all take effect at the clock edge that samples them. The resulting address, status, ready and request values can therefore be read on the falling edge that ends the stimulus cycle. CPU buffer data is registered once, so it is due one cycle after cpu_rd_en and is sampled on the falling edge after that strobe. The bench drives every input on a falling edge and reads every result on a later falling edge. The register read port is combinational and is sampled a small delay after its select is set.

// File: rtl/dbb_pkg.sv
package dbb_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_HADDR = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_TRIG  = 2'd3
  } reg_sel_e;

  localparam int ST_FLAG = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_HALT = 2;
  localparam int ST_DREQ = 3;

  typedef struct packed {
    logic bank;
    logic irq_en;
    logic inc_en;
  } ctrl_t;

endpackage

// File: rtl/dbb_regs.sv
module dbb_regs
  import dbb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               host_blocked,
  input  logic               end_hit,
  input  logic [BYTE_AW-1:0] haddr,
  output ctrl_t              ctrl,
  output logic               halted,
  output logic               dreq,
  output logic               bank_flag,
  output logic               overrun,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               haddr_load,
  output logic [BYTE_AW-1:0] haddr_load_val,
  output logic               bank_swap
);

  logic wr_ctrl, wr_haddr, wr_stat, wr_trig;
  logic trig_hit, clr_flag, clr_ovr;
  ctrl_t ctrl_q, ctrl_d;
  logic halted_q, halted_d, dreq_q, dreq_d;
  logic flag_q, flag_d, ovr_q, ovr_d;
  logic hs_en, flag_en, ovr_en;
  logic unused_wdata;

  assign wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_haddr = cfg_we && (cfg_sel == SEL_HADDR);
  assign wr_stat  = cfg_we && (cfg_sel == SEL_STAT);
  assign wr_trig  = cfg_we && (cfg_sel == SEL_TRIG);

  assign trig_hit = wr_trig && cfg_wdata[0];
  assign clr_flag = wr_stat && cfg_wdata[ST_FLAG];
  assign clr_ovr  = wr_stat && cfg_wdata[ST_OVR];

  assign unused_wdata = ^cfg_wdata[DATA_W-1:BYTE_AW];

  // next-state
  always_comb begin
    ctrl_d   = ctrl_t'(cfg_wdata[2:0]);
    halted_d = halted_q;
    dreq_d   = dreq_q;
    if (trig_hit) begin
      halted_d = 1'b0;
      dreq_d   = 1'b1;
    end
    if (end_hit) begin
      halted_d = 1'b1;
      dreq_d   = 1'b0;
    end
    flag_d = flag_q;
    if (clr_flag) flag_d = 1'b0;
    if (end_hit)  flag_d = 1'b1;
    ovr_d = ovr_q;
    if (clr_ovr)      ovr_d = 1'b0;
    if (host_blocked) ovr_d = 1'b1;
  end

  assign hs_en   = trig_hit | end_hit;
  assign flag_en = clr_flag | end_hit;
  assign ovr_en  = clr_ovr | host_blocked;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      halted_q <= 1'b0;
      dreq_q   <= 1'b0;
      flag_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (hs_en) begin
        halted_q <= halted_d;
        dreq_q   <= dreq_d;
      end
      if (flag_en) flag_q <= flag_d;
      if (ovr_en)  ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_CTRL:  cfg_rdata[2:0] = ctrl_q;
      SEL_HADDR: cfg_rdata[BYTE_AW-1:0] = haddr;
      SEL_STAT: begin
        cfg_rdata[ST_FLAG] = flag_q;
        cfg_rdata[ST_OVR]  = ovr_q;
        cfg_rdata[ST_HALT] = halted_q;
        cfg_rdata[ST_DREQ] = dreq_q;
      end
      default:   cfg_rdata = '0;
    endcase
  end

  assign ctrl           = ctrl_q;
  assign halted         = halted_q;
  assign dreq           = dreq_q;
  assign bank_flag      = flag_q;
  assign overrun        = ovr_q;
  assign haddr_load     = wr_haddr;
  assign haddr_load_val = {cfg_wdata[BYTE_AW-1:2], 2'b00};
  assign bank_swap      = wr_ctrl && (cfg_wdata[2] != ctrl_q.bank);

endmodule

// File: rtl/dbb_addr_ctr.sv
module dbb_addr_ctr #(
  parameter int BYTE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BYTE_AW-1:0] load_val,
  input  logic               swap,
  input  logic               step,
  output logic [BYTE_AW-1:0] haddr,
  output logic               at_end
);

  localparam logic [BYTE_AW-1:0] WORD_STEP = BYTE_AW'(4);
  localparam logic [BYTE_AW-1:0] END_ADDR  = {{(BYTE_AW-2){1'b1}}, 2'b00};

  logic [BYTE_AW-1:0] addr_q, addr_d;
  logic               addr_en;

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = load_val;
    else if (swap) addr_d = '0;
    else if (step) addr_d = addr_q + WORD_STEP;
  end

  assign addr_en = load | swap | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign haddr  = addr_q;
  assign at_end = (addr_q == END_ADDR);

endmodule

// File: rtl/dbb_bank_ram.sv
module dbb_bank_ram #(
  parameter int  DATA_W     = 32,
  parameter int  BANK_WORDS = 64,
  localparam int WAW        = $clog2(BANK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [WAW-1:0]    wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [WAW:0]      rd_addr,
  input  logic              host_bank,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] bank_word [2];
  logic [DATA_W-1:0] rd_q, rd_d;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_idx] <= wr_data;
    end

    assign bank_word[b] = mem[rd_addr[WAW-1:0]];
  end

  always_comb begin
    if (rd_addr[WAW] != host_bank) rd_d = bank_word[rd_addr[WAW]];
    else                           rd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/dual_bank_dma_buf.sv
module dual_bank_dma_buf
  import dbb_pkg::*;
#(
  parameter int  DATA_W     = 32,
  parameter int  BANK_WORDS = 64,
  localparam int WAW        = $clog2(BANK_WORDS),
  localparam int BYTE_AW    = WAW + 2,
  localparam int CPU_AW     = WAW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_valid,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              host_wr_ready,
  output logic              host_dreq,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              cpu_rd_en,
  input  logic [CPU_AW-1:0] cpu_rd_addr,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic              bank_irq
);

  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  ctrl_t              ctrl;
  logic               host_bank, inc_en;
  logic               halted, bank_flag, overrun;
  logic               host_accept, host_blocked, end_hit, at_end;
  logic [BYTE_AW-1:0] haddr, haddr_load_val;
  logic               haddr_load, bank_swap;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign host_bank    = ctrl.bank;
  assign inc_en       = ctrl.inc_en;
  assign host_accept  = host_wr_valid && !halted;
  assign host_blocked = host_wr_valid && halted;
  assign end_hit      = host_accept && at_end;

  dbb_regs #(.DATA_W(DATA_W), .BYTE_AW(BYTE_AW)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cfg_we         (cfg_we),
    .cfg_sel        (cfg_sel),
    .cfg_wdata      (cfg_wdata),
    .host_blocked   (host_blocked),
    .end_hit        (end_hit),
    .haddr          (haddr),
    .ctrl           (ctrl),
    .halted         (halted),
    .dreq           (host_dreq),
    .bank_flag      (bank_flag),
    .overrun        (overrun),
    .cfg_rdata      (cfg_rdata),
    .haddr_load     (haddr_load),
    .haddr_load_val (haddr_load_val),
    .bank_swap      (bank_swap)
  );

  dbb_addr_ctr #(.BYTE_AW(BYTE_AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (haddr_load),
    .load_val (haddr_load_val),
    .swap     (bank_swap),
    .step     (host_accept && inc_en),
    .haddr    (haddr),
    .at_end   (at_end)
  );

  dbb_bank_ram #(.DATA_W(DATA_W), .BANK_WORDS(BANK_WORDS)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (host_accept),
    .wr_bank   (host_bank),
    .wr_idx    (haddr[BYTE_AW-1:2]),
    .wr_data   (host_wr_data),
    .rd_en     (cpu_rd_en),
    .rd_addr   (cpu_rd_addr),
    .host_bank (host_bank),
    .rd_data   (cpu_rd_data)
  );

  assign host_wr_ready = !halted;
  assign bank_irq      = bank_flag && ctrl.irq_en;

endmodule

// File: rtl/dbb_checker.sv
module dbb_checker
  import dbb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_AW = 8,
  parameter int CPU_AW  = 7
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               host_wr_valid,
  input logic               host_wr_ready,
  input logic               host_dreq,
  input logic               cfg_we,
  input logic [1:0]         cfg_sel,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [BYTE_AW-1:0] haddr,
  input logic               host_bank,
  input logic               inc_en,
  input logic               bank_flag,
  input logic               overrun,
  input logic               cpu_rd_en,
  input logic [CPU_AW-1:0]  cpu_rd_addr,
  input logic [DATA_W-1:0]  cpu_rd_data
);

  logic wr_trig, clr_flag, wr_haddr, wr_swap, end_acc, acc;
  logic unused_bits;

  assign wr_trig  = cfg_we && (cfg_sel == SEL_TRIG) && cfg_wdata[0];
  assign clr_flag = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[0];
  assign wr_haddr = cfg_we && (cfg_sel == SEL_HADDR);
  assign wr_swap  = cfg_we && (cfg_sel == SEL_CTRL) && (cfg_wdata[2] != host_bank);
  assign acc      = host_wr_valid && host_wr_ready;
  assign end_acc  = acc && (haddr[BYTE_AW-1:2] == '1);
  assign unused_bits = ^{cfg_wdata[DATA_W-1:3], cfg_wdata[1]};

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && inc_en && !wr_haddr && !wr_swap) |=> (haddr == BYTE_AW'($past(haddr) + BYTE_AW'(4))));

  assert_end_halt_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    end_acc |=> (!host_wr_ready && !host_dreq && bank_flag));

  assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_wr_valid && !host_wr_ready && !wr_haddr && !wr_swap) |=> ($stable(haddr) && overrun));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bank_flag && !clr_flag) |=> bank_flag);

  assert_trig_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_trig && !end_acc) |=> (host_dreq && host_wr_ready));

  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_swap |=> (haddr == '0));

  assert_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_rd_en && (cpu_rd_addr[CPU_AW-1] == host_bank)) |=> (cpu_rd_data == '0));

endmodule

bind dual_bank_dma_buf dbb_checker #(
  .DATA_W (DATA_W),
  .BYTE_AW(BYTE_AW),
  .CPU_AW (CPU_AW)
) u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .host_wr_valid(host_wr_valid),
  .host_wr_ready(host_wr_ready),
  .host_dreq    (host_dreq),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_wdata    (cfg_wdata),
  .haddr        (haddr),
  .host_bank    (host_bank),
  .inc_en       (inc_en),
  .bank_flag    (bank_flag),
  .overrun      (overrun),
  .cpu_rd_en    (cpu_rd_en),
  .cpu_rd_addr  (cpu_rd_addr),
  .cpu_rd_data  (cpu_rd_data)
);

// File: tb/tb_dual_bank_dma_buf.sv
`timescale 1ns/1ps
module tb_dual_bank_dma_buf;

  logic        clk;
  logic        rst_n;
  logic        host_wr_valid;
  logic [31:0] host_wr_data;
  logic        host_wr_ready;
  logic        host_dreq;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cpu_rd_en;
  logic [6:0]  cpu_rd_addr;
  logic [31:0] cpu_rd_data;
  logic        bank_irq;

  int checks = 0;
  int errors = 0;
  logic        hb;
  logic [31:0] rv;

  localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_STAT = 2'd2, S_TRIG = 2'd3;

  // {start byte address, data word}
  localparam logic [39:0] VEC [6] = '{
    {8'h00, 32'hA5A5_0001},
    {8'h04, 32'h5A5A_0002},
    {8'h3C, 32'hDEAD_BEEF},
    {8'h80, 32'h0000_0000},
    {8'hF0, 32'hFFFF_FFFF},
    {8'hF8, 32'h1234_5678}
  };

  dual_bank_dma_buf dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .host_wr_ready(host_wr_ready), .host_dreq(host_dreq),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_addr(cpu_rd_addr), .cpu_rd_data(cpu_rd_data),
    .bank_irq(bank_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] v);
    cfg_sel = sel;
    #1;
    v = cfg_rdata;
  endtask

  task automatic host_write(input logic [31:0] d);
    @(negedge clk);
    host_wr_valid = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic cpu_read(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    cpu_rd_en = 1'b1; cpu_rd_addr = a;
    @(negedge clk);
    cpu_rd_en = 1'b0;
    v = cpu_rd_data;
  endtask

  function automatic logic [31:0] ctrl_word(input logic inc, input logic irq, input logic bank);
    return {29'd0, bank, irq, inc};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr_valid = 1'b0; host_wr_data = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    cpu_rd_en = 1'b0; cpu_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 dreq", {31'd0, host_dreq}, 32'd0);
    chk("R1 irq", {31'd0, bank_irq}, 32'd0);
    chk("R1 ready", {31'd0, host_wr_ready}, 32'd1);
    chk("R1 rd_data", cpu_rd_data, 32'd0);
    cfg_read(S_CTRL, rv); chk("R1 ctrl", rv, 32'd0);
    cfg_read(S_ADDR, rv); chk("R1 haddr", rv, 32'd0);
    cfg_read(S_STAT, rv); chk("R1 status", rv, 32'd0);

    // vector table: write, advance, swap, read back from the released bank
    hb = 1'b0;
    cfg_write(S_CTRL, ctrl_word(1'b1, 1'b0, hb));
    for (int i = 0; i < 6; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = VEC[i][39:32];
      d = VEC[i][31:0];
      cfg_write(S_ADDR, {24'd0, a});
      host_write(d);
      cfg_read(S_ADDR, rv); chk("R3 increment", rv, {24'd0, 8'(a + 8'd4)});
      hb = ~hb;
      cfg_write(S_CTRL, ctrl_word(1'b1, 1'b0, hb));
      cfg_read(S_ADDR, rv); chk("R8 swap wraps", rv, 32'd0);
      cpu_read({~hb, a[7:2]}, rv); chk("R2 readback", rv, d);
    end

    // R10 alignment of software load
    cfg_write(S_ADDR, 32'h37);
    cfg_read(S_ADDR, rv); chk("R10 aligned load", rv, 32'h34);

    // R3 increment off: address holds, second write overwrites
    cfg_write(S_CTRL, ctrl_word(1'b0, 1'b0, hb));
    cfg_write(S_ADDR, 32'h10);
    host_write(32'h1111_1111);
    cfg_read(S_ADDR, rv); chk("R3 hold", rv, 32'h10);
    host_write(32'h2222_2222);
    hb = ~hb;
    cfg_write(S_CTRL, ctrl_word(1'b0, 1'b0, hb));
    cpu_read({~hb, 6'd4}, rv); chk("R3 overwrite", rv, 32'h2222_2222);

    // R9 CPU read of host-owned bank
    cfg_write(S_ADDR, 32'h20);
    host_write(32'h3333_3333);
    cpu_read({hb, 6'd8}, rv); chk("R9 hidden bank", rv, 32'd0);

    // end of bank sequence
    cfg_write(S_CTRL, ctrl_word(1'b1, 1'b1, hb));
    cfg_write(S_ADDR, 32'h0);
    host_write(32'hCAFE_0000);
    cfg_write(S_ADDR, 32'hF8);
    cfg_write(S_TRIG, 32'h1);
    chk("R7 dreq raised", {31'd0, host_dreq}, 32'd1);
    cfg_read(S_TRIG, rv); chk("R7 trig reads 0", rv, 32'd0);
    host_write(32'hAAAA_0001);
    chk("R4 not yet halted", {31'd0, host_wr_ready}, 32'd1);
    host_write(32'hBBBB_0002);
    chk("R4 ready low", {31'd0, host_wr_ready}, 32'd0);
    chk("R4 dreq low", {31'd0, host_dreq}, 32'd0);
    cfg_read(S_STAT, rv); chk("R4 status", rv, 32'h5);
    chk("R6 irq", {31'd0, bank_irq}, 32'd1);

    // R5 write while halted
    host_write(32'hEEEE_EEEE);
    cfg_read(S_STAT, rv); chk("R5 overrun", rv, 32'h7);
    cfg_read(S_ADDR, rv); chk("R5 addr unchanged", rv, 32'd0);

    // swap with irq disabled; flag stays
    hb = ~hb;
    cfg_write(S_CTRL, ctrl_word(1'b1, 1'b0, hb));
    chk("R6 irq gated", {31'd0, bank_irq}, 32'd0);
    cfg_read(S_STAT, rv); chk("R6 flag sticky", rv, 32'h7);
    cpu_read({~hb, 6'd0}, rv); chk("R5 word untouched", rv, 32'hCAFE_0000);
    cpu_read({~hb, 6'd63}, rv); chk("R2 last word", rv, 32'hBBBB_0002);
    cpu_read({~hb, 6'd62}, rv); chk("R2 primed word", rv, 32'hAAAA_0001);

    // write-one-to-clear
    cfg_write(S_STAT, 32'h1);
    cfg_read(S_STAT, rv); chk("R6 flag cleared", rv, 32'h6);
    cfg_write(S_STAT, 32'h2);
    cfg_read(S_STAT, rv); chk("R5 overrun cleared", rv, 32'h4);

    // re-arm
    cfg_write(S_TRIG, 32'h1);
    chk("R7 dreq re-armed", {31'd0, host_dreq}, 32'd1);
    chk("R7 ready restored", {31'd0, host_wr_ready}, 32'd1);
    cfg_read(S_STAT, rv); chk("R7 status", rv, 32'h8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule